// File: doc/BRIEF.md
# Idle-Slot Debug Bus Accessor

This block lets a debug port read and write on-chip memory while the processor keeps running. It takes one request at a time: address, write data, direction, access size and a tag that says which kind of memory the address falls in. It holds the request until it sees a clock cycle in which the processor leaves the shared internal bus unused. It then places the transfer on the bus in that free cycle, so the program is never held up.

Registers and RAM take both reads and writes. The two non-volatile regions, EEPROM and Flash, are read-only from the debug side. A write aimed at them is refused without touching the bus and is reported with an error flag. The bus is 16 bits wide by default and carries byte enables. Byte accesses are steered to the lane that the low address bit selects. The serial command layer that feeds the requests and the memories behind the bus belong to other blocks.

Top module: `dbg_idle_access`

## Requirements
- R1: While `rst` is high and in the first cycle after it, every output is zero: strobes, byte enables, `done`, `error`, `overrun` and `rdata`.
- R2: Neither `bus_rd_stb` nor `bus_wr_stb` is ever high in a cycle in which `cpu_busy` is high.
- R3: A legal request accepted at a clock edge is placed on the bus in the first later cycle in which `cpu_busy` is low, and in no other cycle. `done` is high for exactly the one following cycle.
- R4: Region codes 2'b00 (registers) and 2'b01 (RAM) accept reads and writes. A word access (`req_size`=1) enables both byte lanes and drives the full write data. A byte access (`req_size`=0) enables only lane `req_addr[0]`, where lane 0 is bits 7:0, and drives write-data bits 7:0 on every lane.
- R5: A write to region code 2'b10 (EEPROM) or 2'b11 (Flash) never raises `bus_wr_stb`. It completes with `done` and `error` both high in the second cycle after acceptance, whatever the state of `cpu_busy`.
- R6: Reads are permitted in all four regions, and a read never sets `error`.
- R7: The address, data, direction, size and region of a pending request stay latched until the request is issued. The bus shows the accepted values even if the request inputs change in the meantime.
- R8: A request presented while another is pending, including the cycle in which the pending one is issued, is ignored. It causes `overrun` to be high for the next cycle only.
- R9: Read data is captured at the end of the cycle that carries the read strobe and is visible on `rdata` from the `done` cycle onward. A word read returns the full word. A byte read returns the selected lane zero-extended. `rdata` does not change until the next read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Debug request present this cycle |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Request write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 1 | 1 = word, 0 = byte |
| req_region | input | 2 | Region tag: 00 registers, 01 RAM, 10 EEPROM, 11 Flash |
| cpu_busy | input | 1 | Processor is using the bus this cycle |
| bus_rdata | input | DATA_W | Read data returned by the bus in the strobe cycle |
| bus_addr | output | ADDR_W | Bus address of the held request |
| bus_wdata | output | DATA_W | Lane-steered bus write data |
| bus_be | output | DATA_W/8 | Byte enables, high only with a strobe |
| bus_rd_stb | output | 1 | Read strobe in the stolen cycle |
| bus_wr_stb | output | 1 | Write strobe in the stolen cycle |
| rdata | output | DATA_W | Captured read data |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Completion was a refused write |
| overrun | output | 1 | A request was ignored in the previous cycle |

## Verification
Assertions check every cycle that no strobe coincides with `cpu_busy` and that a write strobe never targets a read-only region. They also check that the latched request stays still while it waits, that `done` never lasts two cycles, that `error` only comes with `done`, and that `rdata` moves only after a read strobe. The bench scenarios are needed to show the exact cycle in which a transfer is issued after a run of busy cycles, and the byte-lane steering of enables and data. They also show that writes really land in memory and read back correctly, that an ignored request leaves the bus showing the first one, and when the overrun pulse appears.

// File: rtl/dbg_acc_pkg.sv
package dbg_acc_pkg;

    typedef enum logic [1:0] {
        RGN_REGS   = 2'b00,
        RGN_RAM    = 2'b01,
        RGN_EEPROM = 2'b10,
        RGN_FLASH  = 2'b11
    } region_e;

    typedef enum logic {
        SZ_BYTE = 1'b0,
        SZ_WORD = 1'b1
    } size_e;

    typedef struct packed {
        logic    write;
        size_e   size;
        region_e region;
    } req_ctl_t;

    localparam int unsigned LANE_W = 8;

    // Non-volatile regions carry the upper code bit.
    function automatic logic region_read_only(region_e r);
        return r[1];
    endfunction

endpackage

// File: rtl/dbg_req_hold.sv
module dbg_req_hold
    import dbg_acc_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  req_ctl_t          req_ctl,
    input  logic              release_i,
    output logic              pending_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output req_ctl_t          ctl_o,
    output logic              overrun_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_o <= 1'b0;
            addr_o    <= '0;
            wdata_o   <= '0;
            ctl_o     <= '0;
            overrun_o <= 1'b0;
        end else begin
            overrun_o <= req_valid && pending_o;
            if (req_valid && !pending_o) begin
                pending_o <= 1'b1;
                addr_o    <= req_addr;
                wdata_o   <= req_wdata;
                ctl_o     <= req_ctl;
            end else if (release_i) begin
                pending_o <= 1'b0;
            end
        end
    end

    // R7
    held_fields_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (pending_o && !release_i) |=> ($stable(addr_o) && $stable(wdata_o) && $stable(ctl_o)));

    // R8
    overrun_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && pending_o) |=> overrun_o);

endmodule

// File: rtl/dbg_lane_mux.sv
module dbg_lane_mux
    import dbg_acc_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  size_e                          size,
    input  logic [LSEL-1:0]                lane_sel,
    input  logic [DATA_W-1:0]              wdata_in,
    input  logic [DATA_W-1:0]              rdata_bus,
    output logic [DATA_W/LANE_W-1:0]       be,
    output logic [DATA_W-1:0]              wdata_bus,
    output logic [DATA_W-1:0]              rdata_ext
);

    localparam int unsigned LANES = DATA_W / LANE_W;
    localparam int unsigned LSEL  = (LANES > 1) ? $clog2(LANES) : 1;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign be[g] = (size == SZ_WORD) || (lane_sel == LSEL'(g));
        assign wdata_bus[g*LANE_W +: LANE_W] =
            (size == SZ_WORD) ? wdata_in[g*LANE_W +: LANE_W] : wdata_in[LANE_W-1:0];
    end

    always_comb begin
        rdata_ext = '0;
        if (size == SZ_WORD) begin
            rdata_ext = rdata_bus;
        end else begin
            rdata_ext[LANE_W-1:0] = rdata_bus[{lane_sel, 3'b000} +: LANE_W];
        end
    end

endmodule

// File: rtl/dbg_idle_access.sv
module dbg_idle_access
    import dbg_acc_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic                     req_write,
    input  logic                     req_size,
    input  logic [1:0]               req_region,
    input  logic                     cpu_busy,
    input  logic [DATA_W-1:0]        bus_rdata,
    output logic [ADDR_W-1:0]        bus_addr,
    output logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W/8-1:0]      bus_be,
    output logic                     bus_rd_stb,
    output logic                     bus_wr_stb,
    output logic [DATA_W-1:0]        rdata,
    output logic                     done,
    output logic                     error,
    output logic                     overrun
);

    localparam int unsigned LANES = DATA_W / LANE_W;
    localparam int unsigned LSEL  = (LANES > 1) ? $clog2(LANES) : 1;

    req_ctl_t          in_ctl;
    req_ctl_t          held_ctl;
    logic              pending;
    logic              fire;
    logic              ro_write;
    logic [ADDR_W-1:0] held_addr;
    logic [DATA_W-1:0] held_wdata;
    logic [LANES-1:0]  lane_be;
    logic [DATA_W-1:0] read_ext;

    assign in_ctl = '{write: req_write, size: size_e'(req_size), region: region_e'(req_region)};

    dbg_req_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) hold_i (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_ctl   (in_ctl),
        .release_i (fire),
        .pending_o (pending),
        .addr_o    (held_addr),
        .wdata_o   (held_wdata),
        .ctl_o     (held_ctl),
        .overrun_o (overrun)
    );

    dbg_lane_mux #(.DATA_W(DATA_W)) lane_i (
        .size      (held_ctl.size),
        .lane_sel  (held_addr[LSEL-1:0]),
        .wdata_in  (held_wdata),
        .rdata_bus (bus_rdata),
        .be        (lane_be),
        .wdata_bus (bus_wdata),
        .rdata_ext (read_ext)
    );

    // Refused writes need no bus slot; legal ones wait for an idle cycle.
    assign ro_write   = held_ctl.write && region_read_only(held_ctl.region);
    assign fire       = pending && (ro_write || !cpu_busy);
    assign bus_rd_stb = fire && !held_ctl.write;
    assign bus_wr_stb = fire && held_ctl.write && !ro_write;
    assign bus_addr   = held_addr;
    assign bus_be     = (bus_rd_stb || bus_wr_stb) ? lane_be : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            done  <= 1'b0;
            error <= 1'b0;
            rdata <= '0;
        end else begin
            done  <= fire;
            error <= fire && ro_write;
            if (bus_rd_stb) begin
                rdata <= read_ext;
            end
        end
    end

    // R2
    idle_slot_only_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_busy |-> !(bus_rd_stb || bus_wr_stb));

    // R5
    no_nv_write_chk: assert property (@(posedge clk) disable iff (rst)
        bus_wr_stb |-> !held_ctl.region[1]);

    // R3
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R5
    error_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        error |-> done);

    // R4
    one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd_stb && bus_wr_stb));

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_rd_stb) |-> $stable(rdata));

endmodule

// File: tb/dbg_idle_access_tb_top.sv
module dbg_idle_access_tb_top;

    localparam int unsigned AW = 8;
    localparam int unsigned DW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata;
    logic          req_write;
    logic          req_size;
    logic [1:0]    req_region;
    logic          cpu_busy;
    logic [DW-1:0] bus_rdata;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [1:0]    bus_be;
    logic          bus_rd_stb;
    logic          bus_wr_stb;
    logic [DW-1:0] rdata;
    logic          done;
    logic          error;
    logic          overrun;

    int checks = 0;
    int fails  = 0;
    logic [DW-1:0] mem     [16];
    logic [DW-1:0] exp_mem [16];
    logic [DW-1:0] last_rd;

    always #5 clk = ~clk;

    dbg_idle_access #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_write(req_write), .req_size(req_size),
        .req_region(req_region), .cpu_busy(cpu_busy), .bus_rdata(bus_rdata),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
        .bus_rd_stb(bus_rd_stb), .bus_wr_stb(bus_wr_stb), .rdata(rdata),
        .done(done), .error(error), .overrun(overrun)
    );

    function automatic logic [DW-1:0] init_word(int i);
        return DW'(i * 16'h1357) ^ 16'hA5C3;
    endfunction

    // Memory behind the bus
    assign bus_rdata = mem[bus_addr[4:1]];
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 16; i++) mem[i] <= init_word(i);
        end else if (bus_wr_stb) begin
            if (bus_be[0]) mem[bus_addr[4:1]][7:0]  <= bus_wdata[7:0];
            if (bus_be[1]) mem[bus_addr[4:1]][15:8] <= bus_wdata[15:8];
        end
    end

    function automatic logic [DW-1:0] exp_read(logic [AW-1:0] a, logic sz);
        logic [DW-1:0] w = exp_mem[a[4:1]];
        if (sz) return w;
        return a[0] ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
    endfunction

    function automatic logic [1:0] exp_be(logic [AW-1:0] a, logic sz);
        if (sz) return 2'b11;
        return a[0] ? 2'b10 : 2'b01;
    endfunction

    function automatic logic [DW-1:0] exp_wdata(logic [DW-1:0] d, logic sz);
        return sz ? d : {d[7:0], d[7:0]};
    endfunction

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic run_req(logic [AW-1:0] a, logic [DW-1:0] d, logic wr, logic sz,
                           logic [1:0] rg, int busy, bit collide);
        bit ro = wr && rg[1];
        int stb_k  = ro ? 0 : busy + 1;
        int done_k = ro ? 2 : busy + 2;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_wdata = d;
        req_write = wr; req_size = sz; req_region = rg; cpu_busy = 1'b1;
        for (int k = 1; k <= done_k; k++) begin
            @(negedge clk);
            req_valid = (k == 1) && collide;
            if (k == 1) begin
                req_addr = ~a; req_wdata = ~d; req_write = ~wr;
                req_size = ~sz; req_region = ~rg;
            end
            cpu_busy = (k <= busy);
            #1;
            chk(!(cpu_busy && (bus_rd_stb || bus_wr_stb)), "R2", "strobe while busy",
                {bus_rd_stb, bus_wr_stb}, 0);
            if (k == stb_k) begin
                chk(bus_rd_stb == !wr && bus_wr_stb == wr, "R3", "strobe kind",
                    {bus_rd_stb, bus_wr_stb}, {!wr, wr});
                chk(bus_addr == a, "R7", "held address", bus_addr, a);
                chk(bus_be == exp_be(a, sz), "R4", "byte enables", bus_be, exp_be(a, sz));
                if (wr) chk(bus_wdata == exp_wdata(d, sz), "R4", "write data",
                            bus_wdata, exp_wdata(d, sz));
            end else begin
                chk(!bus_rd_stb && !bus_wr_stb, ro ? "R5" : "R3", "stray strobe",
                    {bus_rd_stb, bus_wr_stb}, 0);
            end
            chk(done == (k == done_k), "R3", "done timing", done, (k == done_k));
            if (collide && k == 2) chk(overrun == 1'b1, "R8", "overrun pulse", overrun, 1);
            if (collide && k == 3) chk(overrun == 1'b0, "R8", "overrun one cycle", overrun, 0);
            if (k == done_k) begin
                chk(error == ro, ro ? "R5" : "R6", "error flag", error, ro);
                if (!wr) begin
                    chk(rdata == exp_read(a, sz), "R9", "read data", rdata, exp_read(a, sz));
                    last_rd = exp_read(a, sz);
                end else begin
                    chk(rdata == last_rd, "R9", "read data held", rdata, last_rd);
                end
            end
        end
        if (wr && !ro) begin
            if (sz) exp_mem[a[4:1]] = d;
            else if (a[0]) exp_mem[a[4:1]][15:8] = d[7:0];
            else exp_mem[a[4:1]][7:0] = d[7:0];
        end
        cpu_busy = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        void'($urandom(32'd7));
        rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_wdata = '0;
        req_write = 1'b0; req_size = 1'b0; req_region = 2'b00; cpu_busy = 1'b0;
        for (int i = 0; i < 16; i++) exp_mem[i] = init_word(i);
        last_rd = '0;
        repeat (3) @(negedge clk);
        #1;
        // R1
        chk(!done && !error && !overrun && rdata == 0 && bus_be == 0 && !bus_rd_stb && !bus_wr_stb,
            "R1", "reset state", {done, error, overrun, bus_rd_stb, bus_wr_stb}, 0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(!done && !error && !overrun && rdata == 0, "R1", "after reset",
            {done, error, overrun}, 0);

        // Directed corners
        run_req(8'h04, 16'hBEEF, 1'b1, 1'b1, 2'b01, 0, 1'b0);  // R4 word write to RAM
        run_req(8'h04, 16'h0000, 1'b0, 1'b1, 2'b01, 3, 1'b0);  // R9 word read after busy
        run_req(8'h05, 16'h0000, 1'b0, 1'b0, 2'b00, 0, 1'b0);  // R9 byte read lane 1
        run_req(8'h06, 16'h1234, 1'b1, 1'b1, 2'b10, 2, 1'b0);  // R5 EEPROM write refused
        run_req(8'h08, 16'h5678, 1'b1, 1'b0, 2'b11, 0, 1'b0);  // R5 Flash write refused
        run_req(8'h06, 16'h0000, 1'b0, 1'b1, 2'b10, 1, 1'b0);  // R6 EEPROM read, unchanged
        run_req(8'h0B, 16'h00C7, 1'b1, 1'b0, 2'b00, 4, 1'b1);  // R7 R8 byte write with collision
        run_req(8'h0A, 16'h0000, 1'b0, 1'b1, 2'b00, 0, 1'b1);  // R8 read with collision
        run_req(8'h09, 16'h0000, 1'b0, 1'b0, 2'b11, 0, 1'b0);  // R6 Flash byte read

        // Random mix
        for (int n = 0; n < 80; n++) begin
            run_req(AW'($urandom_range(0, 31)), DW'($urandom),
                    1'($urandom), 1'($urandom), 2'($urandom),
                    $urandom_range(0, 4), ($urandom_range(0, 5) == 0));
        end
        // Read back every word
        for (int i = 0; i < 16; i++) run_req(AW'(i * 2), '0, 1'b0, 1'b1, 2'b01, i % 3, 1'b0);

        finish_up();
    end

endmodule